// File: doc/BRIEF.md
# Discriminator Bit Frame Packer

The packer takes the one-bit fast-discriminator results of two 64-channel front-end modules. That is a 128-bit snapshot, offered once per beam-crossing period. It turns the snapshot into a stream of 20-bit words for an external 7:1 serializer. Each module owns a 10-bit lane of every word. A full crossing is spread over a frame of seven words, one word per word clock, and a 21st output bit marks the first word of each frame.

A snapshot is offered with a single-cycle strobe. It is never applied in the middle of a frame. The block keeps it and switches to it at the next frame start, so every frame carries bits from exactly one crossing. If no new strobe arrives, the last snapshot is sent again. Until the first strobe after reset, the block sends all-zero frames with the normal frame-marker cadence.

Top module: `disc_frame_packer`

## Requirements
- R1: While reset is asserted, and in the first word clock after release, `word_o` is all zero and `frame_o` is high (word index 0).
- R2: `frame_o` is high on exactly one word clock out of every 7, namely word index 0 of each frame, and low on the other six.
- R3: In word k (k = 0..6) of a frame, `word_o[j]` carries channel 10k+j of module A (`snap_i[10k+j]`), and `word_o[10+j]` carries channel 10k+j of module B (`snap_i[64+10k+j]`), for j = 0..9.
- R4: The six slots per module past channel 63 are always 0. These are bits [9:4] and [19:14] of word index 6.
- R5: A strobe (`snap_vld_i` high for one clock) sampled on word index 0..5 does not alter the frame in progress. Its snapshot is emitted from the next frame start onward.
- R6: When several strobes are sampled within one frame, the last one wins at the next frame start.
- R7: A frame with no strobe repeats the previous frame's snapshot unchanged. Before any strobe after reset, that snapshot is all zeros.
- R8: A strobe sampled on word index 6 is emitted in the frame that starts on the following word clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| snap_i | input | 128 | Discriminator snapshot: [63:0] module A, [127:64] module B, bit = channel |
| snap_vld_i | input | 1 | Snapshot strobe, one clock per crossing |
| word_o | output | 20 | Packed word: [9:0] module A lane, [19:10] module B lane |
| frame_o | output | 1 | Frame marker, high on word index 0 |

## Verification
On every clock, the assertions check four things. The frame marker must follow an independent 7-phase count. Spare slots must read zero. The active snapshot must be frozen everywhere but the frame boundary, and a strobe on the last word must be taken up at once. The word-0 lane mapping and the idle-repeat rule are checked per cycle as well. The full channel-to-slot ordering across all seven words can only be shown by the bench's scoreboard: it compares every emitted word against frames built from distinct patterns. The same holds for the ordering effects of strobes at different phases, for overwrites within a frame, and for idle repeats.

// File: rtl/dfp_pkg.sv
package dfp_pkg;
  parameter int unsigned MOD_CH      = 64;
  parameter int unsigned LANE_W      = 10;
  parameter int unsigned FRAME_WORDS = 7;
  parameter int unsigned NUM_MOD     = 2;

  localparam int unsigned WORD_W = LANE_W * NUM_MOD;
  localparam int unsigned SNAP_W = MOD_CH * NUM_MOD;
  localparam int unsigned SLOT_W = LANE_W * FRAME_WORDS;
  localparam int unsigned IDX_W  = $clog2(FRAME_WORDS);
endpackage

// File: rtl/dfp_word_counter.sv
module dfp_word_counter #(
  parameter int unsigned N_WORDS = 7,
  parameter int unsigned IDX_W   = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [IDX_W-1:0] idx_o,
  output logic             first_o,
  output logic             last_o
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_WORDS - 1);

  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              idx_q <= '0;
    else if (idx_q == LAST_IDX) idx_q <= '0;
    else                      idx_q <= idx_q + 1'b1;
  end

  assign idx_o   = idx_q;
  assign first_o = (idx_q == '0);
  assign last_o  = (idx_q == LAST_IDX);
endmodule

// File: rtl/dfp_snap_stage.sv
module dfp_snap_stage #(
  parameter int unsigned SNAP_W = 128
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [SNAP_W-1:0] snap_i,
  input  logic              vld_i,
  input  logic              load_i,   // last word of frame
  output logic [SNAP_W-1:0] act_o
);
  logic [SNAP_W-1:0] hold_q, act_q;
  logic              pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
    end else if (load_i) begin
      // a strobe on the last word bypasses the holding register
      pend_q <= 1'b0;
      if (vld_i)       act_q <= snap_i;
      else if (pend_q) act_q <= hold_q;
    end else if (vld_i) begin
      hold_q <= snap_i;
      pend_q <= 1'b1;
    end
  end

  assign act_o = act_q;
endmodule

// File: rtl/dfp_lane_sel.sv
module dfp_lane_sel #(
  parameter int unsigned MOD_CH  = 64,
  parameter int unsigned LANE_W  = 10,
  parameter int unsigned N_WORDS = 7,
  parameter int unsigned IDX_W   = 3
) (
  input  logic [MOD_CH-1:0] mod_i,
  input  logic [IDX_W-1:0]  idx_i,
  output logic [LANE_W-1:0] lane_o
);
  localparam int unsigned SLOT_W = LANE_W * N_WORDS;
  localparam int unsigned PAD_W  = SLOT_W - MOD_CH;

  logic [SLOT_W-1:0] slots;

  generate
    if (PAD_W > 0) begin : g_pad
      assign slots = {{PAD_W{1'b0}}, mod_i};
    end else begin : g_nopad
      assign slots = mod_i[SLOT_W-1:0];
    end
  endgenerate

  assign lane_o = slots[idx_i*LANE_W +: LANE_W];
endmodule

// File: rtl/disc_frame_packer.sv
module disc_frame_packer
  import dfp_pkg::*;
#(
  parameter int unsigned P_MOD_CH  = MOD_CH,
  parameter int unsigned P_LANE_W  = LANE_W,
  parameter int unsigned P_N_WORDS = FRAME_WORDS,
  parameter int unsigned P_NUM_MOD = NUM_MOD
) (
  input  logic                                clk_i,
  input  logic                                rst_ni,
  input  logic [P_MOD_CH*P_NUM_MOD-1:0]       snap_i,
  input  logic                                snap_vld_i,
  output logic [P_LANE_W*P_NUM_MOD-1:0]       word_o,
  output logic                                frame_o
);
  localparam int unsigned L_SNAP_W = P_MOD_CH * P_NUM_MOD;
  localparam int unsigned L_IDX_W  = $clog2(P_N_WORDS);

  logic [L_IDX_W-1:0]  idx_w;
  logic                first_w, last_w;
  logic [L_SNAP_W-1:0] act_w;

  dfp_word_counter #(
    .N_WORDS(P_N_WORDS),
    .IDX_W  (L_IDX_W)
  ) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .idx_o  (idx_w),
    .first_o(first_w),
    .last_o (last_w)
  );

  dfp_snap_stage #(
    .SNAP_W(L_SNAP_W)
  ) u_stage (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .snap_i(snap_i),
    .vld_i (snap_vld_i),
    .load_i(last_w),
    .act_o (act_w)
  );

  for (genvar m = 0; m < P_NUM_MOD; m++) begin : g_lane
    dfp_lane_sel #(
      .MOD_CH (P_MOD_CH),
      .LANE_W (P_LANE_W),
      .N_WORDS(P_N_WORDS),
      .IDX_W  (L_IDX_W)
    ) u_sel (
      .mod_i (act_w[m*P_MOD_CH +: P_MOD_CH]),
      .idx_i (idx_w),
      .lane_o(word_o[m*P_LANE_W +: P_LANE_W])
    );
  end

  assign frame_o = first_w;
endmodule

// File: rtl/disc_frame_packer_chk.sv
module disc_frame_packer_chk #(
  parameter int unsigned P_MOD_CH  = 64,
  parameter int unsigned P_LANE_W  = 10,
  parameter int unsigned P_N_WORDS = 7,
  parameter int unsigned P_NUM_MOD = 2
) (
  input logic                          clk_i,
  input logic                          rst_ni,
  input logic [P_MOD_CH*P_NUM_MOD-1:0] snap_i,
  input logic                          snap_vld_i,
  input logic [P_LANE_W*P_NUM_MOD-1:0] word_o,
  input logic                          frame_o,
  input logic [P_MOD_CH*P_NUM_MOD-1:0] act_i
);
  localparam int unsigned PH_W = $clog2(P_N_WORDS);
  localparam logic [PH_W-1:0] PH_LAST = PH_W'(P_N_WORDS - 1);
  localparam int unsigned USED = P_MOD_CH - (P_N_WORDS - 1) * P_LANE_W;

  logic [PH_W-1:0] ph_q;
  logic            seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= '0;
      seen_q <= 1'b0;
    end else begin
      ph_q   <= (ph_q == PH_LAST) ? '0 : ph_q + 1'b1;
      seen_q <= (ph_q == PH_LAST) ? 1'b0 : (seen_q | snap_vld_i);
    end
  end

  p_frame_cadence_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_o == (ph_q == '0));

  p_frozen_midframe_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q != '0) |-> $stable(act_i));

  p_last_word_take_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_LAST && snap_vld_i) |=> act_i == $past(snap_i));

  p_idle_repeat_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ph_q == PH_LAST && !snap_vld_i && !seen_q) |=> $stable(act_i));

  for (genvar m = 0; m < P_NUM_MOD; m++) begin : g_mod
    p_spare_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ph_q == PH_LAST) |-> word_o[m*P_LANE_W + USED +: (P_LANE_W - USED)] == '0);

    p_first_map_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ph_q == '0) |-> word_o[m*P_LANE_W +: P_LANE_W] == act_i[m*P_MOD_CH +: P_LANE_W]);
  end
endmodule

bind disc_frame_packer disc_frame_packer_chk #(
  .P_MOD_CH (P_MOD_CH),
  .P_LANE_W (P_LANE_W),
  .P_N_WORDS(P_N_WORDS),
  .P_NUM_MOD(P_NUM_MOD)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .snap_i    (snap_i),
  .snap_vld_i(snap_vld_i),
  .word_o    (word_o),
  .frame_o   (frame_o),
  .act_i     (act_w)
);

// File: tb/test_disc_frame_packer.sv
module test_disc_frame_packer;
  typedef struct {
    logic [19:0] d;
    logic        f;
    int          tag;
  } item_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [127:0] snap = '0;
  logic         vld = 1'b0;
  logic [19:0]  word;
  logic         frame;

  int n_chk = 0;
  int n_fail = 0;
  int cur_tag = 7;
  bit done = 0;

  item_t        q[$];
  int           ref_ph = 0;
  logic [127:0] ref_cur = '0, ref_hold = '0;
  bit           ref_pend = 0;

  always #2 clk = ~clk;

  disc_frame_packer i_disc_frame_packer (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .snap_i    (snap),
    .snap_vld_i(vld),
    .word_o    (word),
    .frame_o   (frame)
  );

  task automatic push_frame(input logic [127:0] s);
    for (int k = 0; k < 7; k++) begin
      item_t it;
      for (int j = 0; j < 10; j++) begin
        int ch;
        ch = k*10 + j;
        it.d[j]    = (ch < 64) ? s[ch] : 1'b0;
        it.d[10+j] = (ch < 64) ? s[64+ch] : 1'b0;
      end
      it.f   = (k == 0);
      it.tag = (k == 6) ? 4 : cur_tag;
      q.push_back(it);
    end
  endtask

  task automatic check(input bit ok, input string req, input logic [19:0] act, input logic [19:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // reference frame model
  always @(posedge clk) begin
    if (rst_n) begin
      if (ref_ph == 6) begin
        if (vld)           ref_cur = snap;
        else if (ref_pend) ref_cur = ref_hold;
        ref_pend = 0;
        push_frame(ref_cur);
      end else if (vld) begin
        ref_hold = snap;
        ref_pend = 1;
      end
      ref_ph = (ref_ph == 6) ? 0 : ref_ph + 1;
    end
  end

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      #1;
      if (rst_n && !done) begin
        if (q.size() == 0) begin
          check(0, "R2 (queue empty)", word, '0);
        end else begin
          item_t it;
          it = q.pop_front();
          check(frame === it.f, "R2 frame", {19'd0, frame}, {19'd0, it.f});
          check(word === it.d, $sformatf("R%0d data", it.tag), word, it.d);
        end
      end
    end
  end

  task automatic wait_phase(input int p);
    while (ref_ph != p) @(negedge clk);
  endtask

  task automatic strobe_at(input int p, input logic [127:0] d);
    wait_phase(p);
    snap = d;
    vld  = 1'b1;
    @(negedge clk);
    vld  = 1'b0;
    snap = ~d;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(word === '0, "R1 word", word, '0);
    check(frame === 1'b1, "R1 frame", {19'd0, frame}, 20'd1);
    cur_tag = 1;
    push_frame('0);
    cur_tag = 7;
    rst_n = 1'b1;
    // R7: zero frames before any strobe
    repeat (7) @(negedge clk);
    // R5, R3: mid-frame strobe applied at next frame
    cur_tag = 5;
    strobe_at(2, {64'h0123_4567_89AB_CDEF, 64'hF0E1_D2C3_B4A5_9687});
    wait_phase(0);
    cur_tag = 3;
    // R7: idle frame repeats
    wait_phase(1);
    cur_tag = 7;
    wait_phase(0);
    wait_phase(1);
    // R6: second strobe overwrites held one
    cur_tag = 6;
    strobe_at(1, {64'hDEAD_BEEF_0000_1111, 64'h2222_3333_4444_5555});
    strobe_at(4, {64'hA5A5_5A5A_C3C3_3C3C, 64'h8001_4002_2004_1008});
    wait_phase(0);
    // R8: strobe on last word
    cur_tag = 8;
    strobe_at(6, {64'h1357_9BDF_2468_ACE0, 64'hFFFF_0000_FFFF_0000});
    wait_phase(1);
    // R4, R3: all ones, spares stay zero
    cur_tag = 4;
    strobe_at(0, {128{1'b1}});
    wait_phase(1);
    cur_tag = 5;
    strobe_at(3, {64'h0000_0000_0000_0001, 64'h8000_0000_0000_0000});
    wait_phase(0);
    wait_phase(1);
    wait_phase(0);
    wait_phase(1);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 4);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule